// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation that missed in a translation cache. It takes a 14-bit virtual address, an access type and the base address of a page directory. It then reads memory through one word-wide load port to walk a two-level table. The 8-bit virtual page number has two parts. Its upper nibble picks a directory entry, and its lower nibble picks one of the 16 four-byte entries in the 64-byte chunk that the directory entry points to. The walk returns either a 16-bit physical address or a fault code.

All three interfaces are valid/ready streams, and a transfer happens on a clock edge where both valid and ready are high.

- **Request side.** The walker takes one request at a time. The request fields and `pd_base` are sampled on the accepting edge.
- **Response side.** The walker holds a response, with its contents unchanged, for as long as the consumer holds `rsp_ready` low.
- **Memory request side.** The memory may stall a request by holding `mem_req_ready` low. The address stays stable while the request is stalled.
- **Memory response side.** There is no ready, because at most one load is ever outstanding. The data may return any number of cycles after the request transfer.

Directory entry format: bit 31 is the valid bit and bits 9:0 are the page frame of the chunk. All other bits are ignored.

PTE format: bit 31 is the valid bit, bit 18 grants read, bit 17 grants write, bit 16 grants execute, and bits 9:0 are the physical page number.

Top module: `ptw_walker`

## Requirements
- R1: During and straight after reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.
- R2: The first memory load of every walk has address `pd_base + 4*va[13:10]`, taken modulo 2^16.
- R3: If the directory word has bit 31 set, exactly one more load follows, at address `{pde[9:0], va[9:6], 2'b00}`.
- R4: If the directory word has bit 31 clear, the walk ends after that single load with `rsp_fault` = 1 and `rsp_pa` = 0.
- R5: A valid PTE that permits the access gives `rsp_fault` = 0 and `rsp_pa = {pte[9:0], va[5:0]}`.
- R6: A PTE with bit 31 clear gives `rsp_fault` = 2 and `rsp_pa` = 0, whatever its permission bits say.
- R7: The access type decides which PTE bit must be set: `req_acc` 0 (load) needs bit 18, 1 (store) needs bit 17, 2 (fetch) needs bit 16, and 3 is never permitted. If a valid PTE lacks that bit, the result is `rsp_fault` = 3 and `rsp_pa` = 0.
- R8: `req_ready` is 0 from the cycle after acceptance through the cycle in which the response transfer completes, and it is 1 in the following cycle.
- R9: While `rsp_ready` is low, `rsp_valid`, `rsp_pa` and `rsp_fault` stay unchanged. While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` stay unchanged.
- R10: The walker ignores `mem_rsp_valid` while no load is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 14 | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| pd_base | input | 16 | Page directory base byte address, sampled at acceptance |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 directory invalid, 2 PTE invalid, 3 permission |
| mem_req_valid | output | 1 | Load request offered |
| mem_req_ready | input | 1 | Memory takes the load |
| mem_req_addr | output | 16 | Byte address of the 32-bit word to load |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rsp_data | input | 32 | Loaded word |

## Verification
Two things can land in the same cycle: the completion of a response transfer, and a following request that is already waiting on `req_valid`. The bench raises the next request while it holds `rsp_ready` low, then releases the response. It checks that `req_ready` stays low up to and including the transfer edge and is high in the next cycle. It also checks that the next walk's first load address belongs to the new request. A second coincidence is a PTE that is invalid and also lacks the needed permission bit; the sweep produces this case often, and the invalid-entry code must win.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int VA_W      = 14;
  parameter int OFF_W     = 6;
  parameter int PTE_BYTES = 4;
  parameter int PA_W      = 16;
  parameter int WORD_W    = 32;

  localparam int IDX_W  = $clog2((1 << OFF_W) / PTE_BYTES);
  localparam int BYTE_W = $clog2(PTE_BYTES);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int DIR_W  = VPN_W - IDX_W;
  localparam int PPN_W  = PA_W - OFF_W;

  localparam int VLD_BIT = WORD_W - 1;
  localparam int PROT_LO = 16;
  localparam int PROT_HI = PROT_LO + 2;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_DIR  = 2'd1,
    FLT_PTE  = 2'd2,
    FLT_PROT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_PTE_REQ, ST_PTE_WAIT, ST_RESP
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [DIR_W-1:0] dir_idx_i,
  input  logic [IDX_W-1:0] chunk_idx_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [PPN_W-1:0] frame_i,
  input  logic             sel_pte_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [PA_W-1:0] dir_addr;
  logic [PA_W-1:0] pte_addr;

  assign dir_addr = base_i + PA_W'({dir_idx_i, {BYTE_W{1'b0}}});

  generate
    if (PPN_W + IDX_W + BYTE_W == PA_W) begin : g_exact
      assign pte_addr = {frame_i, chunk_idx_i, {BYTE_W{1'b0}}};
    end else begin : g_fit
      assign pte_addr = PA_W'({frame_i, chunk_idx_i, {BYTE_W{1'b0}}});
    end
  endgenerate

  assign addr_o = sel_pte_i ? pte_addr : dir_addr;
endmodule

// File: rtl/ptw_check.sv
module ptw_check
  import ptw_pkg::*;
(
  input  logic             pte_vld_i,
  input  logic [2:0]       pte_prot_i,
  input  logic [PPN_W-1:0] pte_ppn_i,
  input  acc_e             acc_i,
  input  logic [OFF_W-1:0] offset_i,
  output fault_e           fault_o,
  output logic [PA_W-1:0]  pa_o
);
  logic allowed;

  always_comb begin
    unique case (acc_i)
      ACC_LOAD:  allowed = pte_prot_i[2];
      ACC_STORE: allowed = pte_prot_i[1];
      ACC_FETCH: allowed = pte_prot_i[0];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!pte_vld_i)    fault_o = FLT_PTE;
    else if (!allowed) fault_o = FLT_PROT;
    else               fault_o = FLT_NONE;
  end

  assign pa_o = (fault_o == FLT_NONE) ? {pte_ppn_i, offset_i} : '0;

  always_comb begin
    if (!pte_vld_i) AST_INVALID_WINS: assert (fault_o == FLT_PTE); // R6
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_acc,
  input  logic [PA_W-1:0]   pd_base,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  walk_state_e      state_q;
  logic [VA_W-1:0]  va_q;
  acc_e             acc_q;
  logic [PA_W-1:0]  base_q;
  logic [PPN_W-1:0] frame_q;
  logic [PA_W-1:0]  pa_q;
  fault_e           fault_q;
  fault_e           chk_fault;
  logic [PA_W-1:0]  chk_pa;
  logic             unused_bits;

  assign unused_bits = ^{mem_rsp_data[VLD_BIT-1:PROT_HI+1], mem_rsp_data[PROT_LO-1:PPN_W]};

  ptw_addr_gen u_addr (
    .dir_idx_i   (va_q[VA_W-1 -: DIR_W]),
    .chunk_idx_i (va_q[OFF_W +: IDX_W]),
    .base_i      (base_q),
    .frame_i     (frame_q),
    .sel_pte_i   (state_q == ST_PTE_REQ),
    .addr_o      (mem_req_addr)
  );

  ptw_check u_check (
    .pte_vld_i  (mem_rsp_data[VLD_BIT]),
    .pte_prot_i (mem_rsp_data[PROT_HI:PROT_LO]),
    .pte_ppn_i  (mem_rsp_data[PPN_W-1:0]),
    .acc_i      (acc_q),
    .offset_i   (va_q[OFF_W-1:0]),
    .fault_o    (chk_fault),
    .pa_o       (chk_pa)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= ACC_LOAD;
      base_q  <= '0;
      frame_q <= '0;
      pa_q    <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_va;
          acc_q   <= acc_e'(req_acc);
          base_q  <= pd_base;
          state_q <= ST_DIR_REQ;
        end
        ST_DIR_REQ: if (mem_req_ready) state_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[VLD_BIT]) begin
            fault_q <= FLT_DIR;
            pa_q    <= '0;
            state_q <= ST_RESP;
          end else begin
            frame_q <= mem_rsp_data[PPN_W-1:0];
            state_q <= ST_PTE_REQ;
          end
        end
        ST_PTE_REQ: if (mem_req_ready) state_q <= ST_PTE_WAIT;
        ST_PTE_WAIT: if (mem_rsp_valid) begin
          fault_q <= chk_fault;
          pa_q    <= chk_pa;
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_PTE_REQ);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = fault_q;

  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R8
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> !req_ready); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_NO_LOAD_AFTER_BAD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_DIR_WAIT && mem_rsp_valid && !mem_rsp_data[VLD_BIT]
    |=> rsp_valid && !mem_req_valid && rsp_fault == FLT_DIR); // R4
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != FLT_NONE |-> rsp_pa == '0); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !req_valid && mem_rsp_valid |=> req_ready && !mem_req_valid); // R10
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic [15:0] pd_base = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int n_vec = 0;
  int n_bad = 0;
  int hs_total = 0;
  logic [15:0] addr_log [4];
  logic [15:0] base_cur = '0;
  logic stray_en = 1'b0;

  always #10 clk = ~clk;

  ptw_walker dut_i (.*);

  function automatic logic [31:0] pde_fn(input int d);
    logic v;
    logic [9:0] fr;
    v  = (d % 5) != 3;
    fr = 10'(256 + d * 7);
    return {v, 11'(d * 3), 10'b0, fr};
  endfunction

  function automatic logic [31:0] pte_fn(input int fr, input int ci);
    logic v;
    logic [2:0] pr;
    logic [9:0] pp;
    v  = ((fr + ci) % 7) != 0;
    pr = 3'((fr * 3 + ci) % 8);
    pp = 10'(fr * 5 + ci * 11);
    return {v, 12'h5A5, pr, 6'h2B, pp};
  endfunction

  function automatic logic [31:0] mem_fn(input logic [15:0] a);
    logic [15:0] off;
    off = a - base_cur;
    if (off < 16'd64) return pde_fn(int'(off >> 2));
    return pte_fn(int'(a[15:6]), int'(a[5:2]));
  endfunction

  initial begin
    int cyc = 0;
    int cnt = 0;
    int lat;
    logic pending = 1'b0;
    logic rv;
    logic [31:0] rd;
    logic [15:0] paddr = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    mem_req_ready = 1'b0;
    forever begin
      @(posedge clk);
      cyc++;
      rv = 1'b0;
      rd = '0;
      if (pending) begin
        if (cnt == 0) begin
          rv = 1'b1;
          rd = mem_fn(paddr);
          pending = 1'b0;
        end else cnt--;
      end
      if (mem_req_valid && mem_req_ready) begin
        addr_log[hs_total % 4] = mem_req_addr;
        hs_total++;
        lat = (hs_total * 7 + 3) % 5;
        if (lat == 0) begin
          rv = 1'b1;
          rd = mem_fn(mem_req_addr);
        end else begin
          pending = 1'b1;
          cnt = lat - 1;
          paddr = mem_req_addr;
        end
      end
      if (stray_en && !rv) begin
        rv = 1'b1;
        rd = 32'h8000_03FF;
      end
      mem_rsp_valid <= rv;
      mem_rsp_data  <= rd;
      mem_req_ready <= (cyc % 4) != 2;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic do_walk(input logic [13:0] va, input logic [1:0] acc, input logic [15:0] base,
                         input int stall, input logic early, input logic [13:0] nva);
    int start;
    int d;
    int ci;
    logic [31:0] pde;
    logic [31:0] pte;
    logic [1:0] ef;
    logic [15:0] epa;
    logic allowed;
    logic ok8;
    logic ok9;
    logic [15:0] pa0;
    logic [1:0] f0;
    req_valid = 1'b1;
    req_va    = va;
    req_acc   = acc;
    pd_base   = base;
    forever begin
      @(posedge clk);
      if (req_ready) break;
    end
    start = hs_total;
    @(negedge clk);
    req_valid = 1'b0;
    ok8 = 1'b1;
    ok9 = 1'b1;
    while (!rsp_valid) begin
      if (req_ready) ok8 = 1'b0;
      @(negedge clk);
    end
    pa0 = rsp_pa;
    f0  = rsp_fault;
    if (early) begin
      req_valid = 1'b1;
      req_va    = nva;
      req_acc   = acc;
      pd_base   = base;
    end
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      if (req_ready) ok8 = 1'b0;
      if (!rsp_valid || rsp_pa != pa0 || rsp_fault != f0) ok9 = 1'b0;
    end
    if (req_ready) ok8 = 1'b0;
    chk(ok9, "R9 response held under back-pressure", {16'(rsp_fault), rsp_pa}, {16'(f0), pa0});

    d   = int'(va[13:10]);
    ci  = int'(va[9:6]);
    pde = pde_fn(d);
    pte = pte_fn(int'(pde[9:0]), ci);
    unique case (acc)
      2'd0: allowed = pte[18];
      2'd1: allowed = pte[17];
      2'd2: allowed = pte[16];
      default: allowed = 1'b0;
    endcase
    epa = '0;
    if (!pde[31]) ef = 2'd1;
    else if (!pte[31]) ef = 2'd2;
    else if (!allowed) ef = 2'd3;
    else begin
      ef = 2'd0;
      epa = {pte[9:0], va[5:0]};
    end

    chk(addr_log[start % 4] == 16'(base + 16'(d * 4)), "R2 directory load address",
        32'(addr_log[start % 4]), 32'(16'(base + 16'(d * 4))));
    if (!pde[31]) begin
      chk(hs_total - start == 1, "R4 single load on invalid directory", hs_total - start, 1);
      chk(rsp_fault == ef && rsp_pa == epa, "R4 directory fault", {rsp_fault, rsp_pa}, {ef, epa});
    end else begin
      chk(hs_total - start == 2, "R3 two loads on valid directory", hs_total - start, 2);
      chk(addr_log[(start + 1) % 4] == {pde[9:0], va[9:6], 2'b00}, "R3 PTE load address",
          32'(addr_log[(start + 1) % 4]), 32'({pde[9:0], va[9:6], 2'b00}));
      if (ef == 2'd0)
        chk(rsp_fault == ef && rsp_pa == epa, "R5 translated address", {rsp_fault, rsp_pa}, {ef, epa});
      else if (ef == 2'd2)
        chk(rsp_fault == ef && rsp_pa == epa, "R6 PTE invalid fault", {rsp_fault, rsp_pa}, {ef, epa});
      else
        chk(rsp_fault == ef && rsp_pa == epa, "R7 permission fault", {rsp_fault, rsp_pa}, {ef, epa});
    end

    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(ok8 && req_ready && !rsp_valid, "R8 single outstanding walk",
        {ok8, req_ready, rsp_valid}, 3'b110);
  endtask

  initial begin
    logic [15:0] bases [3];
    bases[0] = 16'h0400;
    bases[1] = 16'h07C4;
    bases[2] = 16'hFFF0;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
        {req_ready, rsp_valid, mem_req_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 after reset release",
        {req_ready, rsp_valid, mem_req_valid}, 3'b100);

    for (int b = 0; b < 3; b++) begin
      base_cur = bases[b];
      stray_en = 1'b1;
      repeat (3) @(negedge clk);
      stray_en = 1'b0;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req_valid, "R10 stray load data ignored",
          {req_ready, rsp_valid, mem_req_valid}, 3'b100);
      for (int v = 0; v < 256; v++) begin
        for (int a = 0; a < 4; a++) begin
          logic [13:0] va;
          logic [13:0] nva;
          logic early;
          va  = {8'(v), 6'((v * 13 + a * 5) % 64)};
          early = (a == 3) && (v < 255);
          nva = {8'(v + 1), 6'((v * 13 + 13) % 64)};
          do_walk(va, 2'(a), bases[b], (v + a) % 3, early, nva);
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule